// File: doc/BRIEF.md
# Periodic Memory CRC Checker

This block watches over a configuration memory while the design runs. After the design enters user mode, it reads the memory one 32-bit word per enabled cycle. It folds every word into a 32-bit CRC. At the end of each pass it combines the final CRC with a stored reference value. The result is a 32-bit signature that is zero only when the memory still matches the reference. The error output is high whenever the signature from the most recent finished pass is non-zero.

The reference comes from a parallel load input, pulsed once when configuration ends. It can also be rewritten bit by bit through a serial scan path. That path is selected by one 10-bit instruction value and is clocked by a shift enable, with TDI in and TDO out. Shifting does not pause the passes, so a deliberately wrong reference shows that the error path works while the checker keeps running. A programmable divider paces the reads. A larger factor gives a slower and longer pass.

Top module: `mem_crc_monitor`

## Requirements
- R1: While reset is held, and until `user_mode` is seen high after reset, `crc_error` is 0 and `mem_rd_en` is 0. Reset also clears the reference register to zero, so `tdo` reads 0.
- R2: Once `user_mode` has been high, passes run back to back until reset, whatever `user_mode` does afterwards. Each pass reads addresses 0 to WORDS-1 in ascending order, one per `mem_rd_en` cycle, and then starts again at 0.
- R3: The read strobe `mem_rd_en` rises only on divider ticks. While `div_factor` is held at F, consecutive ticks are exactly F+1 clock cycles apart.
- R4: The CRC of a pass starts at 32'hFFFFFFFF. For each word, the word is XORed into the CRC, and then 32 shift-right steps are applied. In each step, if bit 0 was set, the shifted value is XORed with 32'hEDB88320, the reflected form of 0x04C11DB7. No final inversion is applied. The signature equals the final CRC XOR the reference register at the clock edge that consumes the last word.
- R5: `crc_error` equals (signature != 0). It changes only at the edge that consumes the last word of a pass, and it stays steady through the whole following pass.
- R6: A later pass whose signature is zero drives `crc_error` low again. No earlier verdict is remembered.
- R7: A `ref_load` cycle copies `ref_value` into the reference register. It wins over a scan shift in the same cycle.
- R8: When `ir_value` equals 10'b0000010101 and `shift_en` is high, each clock moves `tdi` into reference bit 31 and shifts the register toward bit 0. `tdo` always shows reference bit 0.
- R9: `shift_en` has no effect on the reference register when `ir_value` holds any other value.
- R10: Memory reads go on at the normal rate while the reference is being shifted.
- R11: A reference written through the scan path sets the verdict of the first pass that ends after the shift completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_mode | input | 1 | Goes high when configuration and initialization are done |
| div_factor | input | DIV_W | Tick period minus one, in base clock cycles |
| mem_rd_addr | output | ADDR_W | Word address being read |
| mem_rd_en | output | 1 | Word at `mem_rd_addr` is consumed at this edge |
| mem_rd_data | input | 32 | Memory word, combinational from `mem_rd_addr` |
| ref_load | input | 1 | Capture `ref_value` into the reference register |
| ref_value | input | 32 | Precomputed reference CRC |
| ir_value | input | 10 | Current instruction register value |
| shift_en | input | 1 | Scan shift enable |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, reference bit 0 |
| crc_error | output | 1 | Verdict of the last finished pass |

## Verification
A wrong CRC state or a wrong word order gives a non-zero signature. That shows up on `crc_error` one edge after the last read of the affected pass, so it appears within one pass length. A fault in the address sequencer or the divider shows up at once on `mem_rd_addr` and in the spacing of `mem_rd_en`. A damaged reference register can be read out on `tdo` within 32 shift cycles. It also flips the verdict at the next pass boundary. A verdict register that updates in the middle of a pass is caught by sampling `crc_error` on every cycle between two pass ends.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  localparam int CRC_W = 32;
  localparam int IR_W  = 10;
  localparam logic [IR_W-1:0]  SCAN_OP   = 10'b0000010101;
  localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED  = 32'hFFFFFFFF;

  // fold one 32-bit word into a reflected CRC-32, bit 0 first
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] acc,
                                                input logic [CRC_W-1:0] word);
    logic [CRC_W-1:0] c;
    c = acc ^ word;
    for (int b = 0; b < CRC_W; b++) begin
      c = c[0] ? ((c >> 1) ^ POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/mcm_tick_div.sv
module mcm_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] factor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q >= factor);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && factor != '0) |=> (!tick || factor != $past(factor))); // R3
endmodule

// File: rtl/mcm_ref_chain.sv
module mcm_ref_chain
  import mcm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CRC_W-1:0] load_val,
  input  logic [IR_W-1:0]  ir,
  input  logic             shift_en,
  input  logic             tdi,
  output logic             tdo,
  output logic [CRC_W-1:0] ref_val
);
  logic [CRC_W-1:0] ref_q, ref_d;
  logic             scan_sel;
  logic             do_shift;

  assign scan_sel = (ir == SCAN_OP);
  assign do_shift = scan_sel && shift_en && !load;

  always_comb begin
    ref_d = ref_q;
    if (load)          ref_d = load_val;
    else if (do_shift) ref_d = {tdi, ref_q[CRC_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  assign tdo     = ref_q[0];
  assign ref_val = ref_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ref_val == $past(load_val))); // R7
  AST_SCAN_TDO: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift |=> (tdo == $past(ref_q[1]) && ref_q[CRC_W-1] == $past(tdi))); // R8
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(scan_sel && shift_en)) |=> $stable(ref_q)); // R9
endmodule

// File: rtl/mcm_pass_engine.sv
module mcm_pass_engine
  import mcm_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_mode,
  input  logic              tick,
  input  logic [CRC_W-1:0]  rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_en,
  output logic              pass_done,
  output logic [CRC_W-1:0]  pass_crc
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

  logic              run_q, run_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CRC_W-1:0]  crc_q, crc_d;
  logic [CRC_W-1:0]  crc_next;
  logic              at_last;

  assign crc_next  = crc_fold(crc_q, rd_data);
  assign at_last   = (addr_q == LAST);
  assign rd_en     = run_q && tick;
  assign pass_done = rd_en && at_last;
  assign pass_crc  = crc_next;
  assign rd_addr   = addr_q;

  always_comb begin
    run_d  = run_q;
    addr_d = addr_q;
    crc_d  = crc_q;
    if (!run_q) begin
      if (user_mode) run_d = 1'b1;
    end else if (tick) begin
      if (at_last) begin
        addr_d = '0;
        crc_d  = CRC_SEED;
      end else begin
        addr_d = addr_q + ADDR_W'(1);
        crc_d  = crc_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      addr_q <= '0;
      crc_q  <= CRC_SEED;
    end else begin
      run_q  <= run_d;
      addr_q <= addr_d;
      crc_q  <= crc_d;
    end
  end

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> (rd_addr == '0 && crc_q == CRC_SEED)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !at_last) |=> (rd_addr == $past(rd_addr) + ADDR_W'(1))); // R2
endmodule

// File: rtl/mem_crc_monitor.sv
module mem_crc_monitor
  import mcm_pkg::*;
#(
  parameter int  WORDS  = 16,
  parameter int  DIV_W  = 8,
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_mode,
  input  logic [DIV_W-1:0]  div_factor,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              mem_rd_en,
  input  logic [31:0]       mem_rd_data,
  input  logic              ref_load,
  input  logic [31:0]       ref_value,
  input  logic [9:0]        ir_value,
  input  logic              shift_en,
  input  logic              tdi,
  output logic              tdo,
  output logic              crc_error
);
  logic             rst_meta_q, rst_sync_q;
  logic             tick;
  logic             pass_done;
  logic [CRC_W-1:0] pass_crc;
  logic [CRC_W-1:0] ref_val;
  logic [CRC_W-1:0] sig_q, sig_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mcm_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .factor (div_factor),
    .tick   (tick)
  );

  mcm_pass_engine #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .user_mode (user_mode),
    .tick      (tick),
    .rd_data   (mem_rd_data),
    .rd_addr   (mem_rd_addr),
    .rd_en     (mem_rd_en),
    .pass_done (pass_done),
    .pass_crc  (pass_crc)
  );

  mcm_ref_chain u_ref (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (ref_load),
    .load_val (ref_value),
    .ir       (ir_value),
    .shift_en (shift_en),
    .tdi      (tdi),
    .tdo      (tdo),
    .ref_val  (ref_val)
  );

  always_comb begin
    sig_d = sig_q;
    if (pass_done) sig_d = pass_crc ^ ref_val;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) sig_q <= '0;
    else             sig_q <= sig_d;
  end

  assign crc_error = |sig_q;

  AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !pass_done |=> $stable(crc_error)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !mem_rd_en |=> $stable(mem_rd_addr)); // R3
endmodule

// File: tb/mem_crc_monitor_bench.sv
module mem_crc_monitor_bench;
  localparam int WORDS = 16;
  localparam int DIV_W = 8;
  localparam int AW    = 4;
  localparam logic [9:0] SCAN = 10'b0000010101;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             user_mode;
  logic [DIV_W-1:0] div_factor;
  logic [AW-1:0]    mem_rd_addr;
  logic             mem_rd_en;
  logic [31:0]      mem_rd_data;
  logic             ref_load;
  logic [31:0]      ref_value;
  logic [9:0]       ir_value;
  logic             shift_en;
  logic             tdi;
  logic             tdo;
  logic             crc_error;

  logic [31:0] mem [WORDS];
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  assign mem_rd_data = mem[mem_rd_addr];

  mem_crc_monitor #(.WORDS(WORDS), .DIV_W(DIV_W)) u_mem_crc_monitor (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .div_factor(div_factor),
    .mem_rd_addr(mem_rd_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
    .ref_load(ref_load), .ref_value(ref_value), .ir_value(ir_value),
    .shift_en(shift_en), .tdi(tdi), .tdo(tdo), .crc_error(crc_error)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_crc();
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int w = 0; w < WORDS; w++) begin
      c = c ^ mem[w];
      for (int b = 0; b < 32; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  // waits for the edge that consumes the last word; returns at the next negedge
  task automatic pass_end(input bit hold_chk, input bit hold_val, input string req);
    bit seen;
    seen = 1'b0;
    while (!seen) begin
      @(negedge clk);
      if (hold_chk) chk(crc_error == hold_val, req, 32'(crc_error), 32'(hold_val));
      seen = mem_rd_en && (mem_rd_addr == AW'(WORDS - 1));
    end
    @(negedge clk);
  endtask

  task automatic load_ref(input logic [31:0] v);
    @(negedge clk);
    ref_value = v;
    ref_load  = 1'b1;
    @(negedge clk);
    ref_load  = 1'b0;
  endtask

  // shift 32 bits; returns what came out of tdo
  task automatic scan32(input logic [9:0] ir, input logic [31:0] din,
                        output logic [31:0] dout, output int reads);
    reads = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      dout[i]  = tdo;
      if (mem_rd_en) reads++;
      ir_value = ir;
      tdi      = din[i];
      shift_en = 1'b1;
    end
    @(negedge clk);
    shift_en = 1'b0;
    ir_value = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(crc_error == 1'b0, "R1 error in reset", 32'(crc_error), 0);
    chk(mem_rd_en == 1'b0, "R1 read in reset", 32'(mem_rd_en), 0);
    chk(tdo == 1'b0, "R1 reference cleared", 32'(tdo), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(mem_rd_en == 1'b0, "R1 idle before user mode", 32'(mem_rd_en), 0);
    end
  endtask

  task automatic t_clean_order();
    logic [AW-1:0] exp_a;
    int n;
    load_ref(model_crc());
    @(negedge clk);
    user_mode = 1'b1;
    @(negedge clk);
    user_mode = 1'b0;  // R2: passes continue regardless
    exp_a = '0;
    n = 0;
    while (n < 2 * WORDS) begin
      if (mem_rd_en) begin
        chk(mem_rd_addr == exp_a, "R2 address order", 32'(mem_rd_addr), 32'(exp_a));
        exp_a = exp_a + AW'(1);
        n++;
      end
      @(negedge clk);
    end
    pass_end(1'b0, 1'b0, "");
    chk(crc_error == 1'b0, "R4 clean pass verdict", 32'(crc_error), 0);
  endtask

  task automatic spacing(input int f);
    int n;
    @(negedge clk);
    div_factor = DIV_W'(f);
    repeat (3) @(negedge clk);
    while (!mem_rd_en) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!mem_rd_en);
      chk(n == f + 1, "R3 tick spacing", 32'(n), 32'(f + 1));
    end
  endtask

  task automatic t_divider();
    spacing(3);
    spacing(0);
  endtask

  task automatic t_corrupt();
    logic [31:0] refv;
    refv = model_crc();
    pass_end(1'b0, 1'b0, "");
    mem[5] = mem[5] ^ 32'h0000_0100;
    pass_end(1'b1, 1'b0, "R5 low until bad pass ends");
    chk(crc_error == ((model_crc() ^ refv) != 0), "R5 corrupt verdict",
        32'(crc_error), 1);
    mem[5] = mem[5] ^ 32'h0000_0100;
    pass_end(1'b1, 1'b1, "R5 held through next pass");
    chk(crc_error == 1'b0, "R6 clean pass clears", 32'(crc_error), 0);
  endtask

  task automatic t_load_priority();
    logic [31:0] good, got;
    int rd;
    good = model_crc();
    @(negedge clk);
    ref_value = good;
    ref_load  = 1'b1;
    ir_value  = SCAN;
    shift_en  = 1'b1;
    tdi       = ~good[31];
    @(negedge clk);
    ref_load  = 1'b0;
    shift_en  = 1'b0;
    ir_value  = '0;
    chk(tdo == good[0], "R7 load over shift", 32'(tdo), 32'(good[0]));
    scan32(SCAN, good, got, rd);
    chk(got == good, "R7 loaded value read out", got, good);
    pass_end(1'b0, 1'b0, "");
    pass_end(1'b0, 1'b0, "");
    chk(crc_error == 1'b0, "R7 loaded reference matches", 32'(crc_error), 0);
  endtask

  task automatic t_scan_inject();
    logic [31:0] good, bad, got;
    int rd;
    good = model_crc();
    bad  = good ^ 32'h8000_0001;
    pass_end(1'b0, 1'b0, "");
    scan32(SCAN, bad, got, rd);
    chk(got == good, "R8 shifted out old reference", got, good);
    chk(rd == 32, "R10 reads during shift", 32'(rd), 32);
    pass_end(1'b0, 1'b0, "");
    chk(crc_error == 1'b1, "R11 injected error", 32'(crc_error), 1);
    // wrong instruction: reference must stay as 'bad'
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      chk(tdo == bad[0], "R9 tdo unchanged", 32'(tdo), 32'(bad[0]));
      ir_value = SCAN ^ 10'h001;
      shift_en = 1'b1;
      tdi      = ~bad[0];
    end
    @(negedge clk);
    shift_en = 1'b0;
    ir_value = '0;
    chk(tdo == bad[0], "R9 tdo after ignored shift", 32'(tdo), 32'(bad[0]));
    pass_end(1'b0, 1'b0, "");
    chk(crc_error == 1'b1, "R9 verdict unchanged", 32'(crc_error), 1);
    scan32(SCAN, good, got, rd);
    chk(got == bad, "R8 read back injected value", got, bad);
    pass_end(1'b0, 1'b0, "");
    chk(crc_error == 1'b0, "R11 restored reference", 32'(crc_error), 0);
  endtask

  task automatic t_reset_mid_run();
    load_ref(32'hDEAD_BEEF);
    pass_end(1'b0, 1'b0, "");
    pass_end(1'b0, 1'b0, "");
    chk(crc_error == 1'b1, "R4 wrong reference flagged", 32'(crc_error), 1);
    rst_n = 1'b0;
    #1;
    chk(crc_error == 1'b0, "R1 reset clears error", 32'(crc_error), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(mem_rd_en == 1'b0 && crc_error == 1'b0, "R1 idle after reset",
          32'({mem_rd_en, crc_error}), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = (32'h9E37_79B9 * (i + 1)) ^ (32'(i) << 7);
    rst_n = 1'b0; user_mode = 1'b0; div_factor = '0; ref_load = 1'b0;
    ref_value = '0; ir_value = '0; shift_en = 1'b0; tdi = 1'b0;
    t_reset();
    t_clean_order();
    t_divider();
    t_corrupt();
    t_load_priority();
    t_scan_inject();
    t_reset_mid_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule